// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block drives one access at a time onto an asynchronous external memory bus. It generates the chip selects, the address, the read and output-enable strobes and the write strobe. The internal side presents a request with a direction flag, an address, a chip-select index, write data and a per-access wait-state count. The block answers with a same-cycle acknowledge, and later with the captured read data and a one-clock completion pulse. The block runs on a clock at twice the bus rate, so each bus cycle is two internal clocks and every strobe edge falls on a half-bus-cycle boundary.

A single configuration bit selects one of two read timings for every chip select at once. In the delayed timing, the read strobe waits one internal clock after chip select and address so that the previous access can clear the bus. In the early timing, the read strobe asserts together with chip select. It then stays low across back-to-back reads to the same device. A one-bus-cycle quiet period follows any early read that is not continued. Writes have the same timing under both settings.

Top module: `ext_strobe_seq`

## Requirements
- R1: The timing bit is written with `cfg_we`/`cfg_early` and resets to 0, which selects delayed-read timing. The value held when a request is accepted applies to that access, whatever its chip select.
- R2: While reset is high and after it, until the first access, all `bus_ncs_n` bits are 1, `bus_rd_n`, `bus_oe_n` and `bus_we_n` are 1, and `bus_dout_en` and `done` are 0.
- R3: A request taken at an edge where `ack` is 1 drives `bus_ncs_n` low on bit `cs` only, and puts `addr` on `bus_addr`, from the next clock. The access then lasts 2*(`wait_states`+1) clocks.
- R4: With timing bit 0, a read holds `bus_rd_n` high in the first clock of the access and low from the second clock to the end.
- R5: With timing bit 1, a read drives `bus_rd_n` low in the same clock that chip select falls.
- R6: Under either timing, a write holds `bus_we_n` high in the first clock and low from the second clock to the end. It drives `bus_dout_en`=1 and `bus_dout`=`wdata` for the whole access.
- R7: `bus_oe_n` equals `bus_rd_n` in every clock.
- R8: `rdata` takes the value of `bus_din` at the edge that ends the last clock of a read. `done` is 1 for exactly the one clock after that edge. At that same edge, chip select and the strobes deassert unless the access continues.
- R9: `ack` is `req` while idle. In the last clock of an early-timing read, `ack` is 1 only for a read to the same chip select. Such a continuation keeps `bus_rd_n` and that chip select low with no gap. `ack` is 0 at all other times.
- R10: An early-timing read that is not continued is followed by two clocks with every strobe and chip select high and `ack` 0. A delayed-timing access never adds these clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing bit |
| cfg_early | input | 1 | New timing bit value (1 = early read) |
| req | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| cs | input | CSW | Chip-select index |
| addr | input | AW | Access address |
| wdata | input | DW | Write data |
| wait_states | input | WSW | Extra bus cycles for this access |
| ack | output | 1 | Request taken at this edge |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| bus_ncs_n | output | NCS | Active-low chip selects |
| bus_addr | output | AW | Bus address |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_dout | output | DW | Write data to the bus |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| bus_din | input | DW | Read data from the bus |

## Verification
The assertions check, on every clock, that at most one chip select is low and that no strobe asserts without one. They also check that read and write strobes never overlap, that the delayed read and the write strobe fall only while chip select and address are steady, and that `done` never lasts two clocks. Other behaviour needs the bench's scenarios and its clock-by-clock model. That covers the exact clock in which each strobe moves, the length set by the wait count, and the edge at which read data is sampled. It also covers continued early reads, the quiet period after an early read that ends, and the reset default of the timing bit.

// File: rtl/esq_pkg.sv
package esq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_GAP  = 2'd2
  } esq_state_e;
endpackage

// File: rtl/esq_timer.sv
module esq_timer
  import esq_pkg::*;
#(
  parameter int CSW = 2,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic           wr,
  input  logic [CSW-1:0] cs,
  input  logic [WSW-1:0] wait_states,
  input  logic           mode_early,
  output logic           ack,
  output logic           step,
  output logic           fin
);
  localparam int CW = WSW + 1;

  esq_state_e     state;
  logic [CW-1:0]  cnt;
  logic           cur_rd;
  logic           cur_early;
  logic [CSW-1:0] cur_cs;
  logic           gap_cnt;
  logic           cont_ok;

  assign fin     = (state == ST_ACT) && (cnt == '0);
  assign step    = (state == ST_ACT) && (cnt != '0);
  assign cont_ok = fin && cur_early && cur_rd && !wr && (cs == cur_cs);
  assign ack     = req && ((state == ST_IDLE) || cont_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cur_rd    <= 1'b0;
      cur_early <= 1'b0;
      cur_cs    <= '0;
      gap_cnt   <= 1'b0;
    end else if (ack) begin
      state     <= ST_ACT;
      cnt       <= {wait_states, 1'b1};
      cur_rd    <= !wr;
      cur_early <= mode_early;
      cur_cs    <= cs;
    end else begin
      case (state)
        ST_ACT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (cur_early && cur_rd) begin
            state   <= ST_GAP;
            gap_cnt <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_GAP: begin
          if (gap_cnt) gap_cnt <= 1'b0;
          else         state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: a quiet period is only entered from an early read
  p_gap_after_early_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACT && $past(state) != ST_GAP && !ack && cnt == '0 && !(cur_early && cur_rd))
      |=> state == ST_IDLE);
endmodule

// File: rtl/esq_drive.sv
module esq_drive #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NCS = 4,
  parameter int CSW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           step,
  input  logic           fin,
  input  logic           wr,
  input  logic [CSW-1:0] cs,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic           mode_early,
  input  logic [DW-1:0]  bus_din,
  output logic [NCS-1:0] ncs_q,
  output logic [AW-1:0]  addr_q,
  output logic           rd_q,
  output logic           oe_q,
  output logic           we_q,
  output logic [DW-1:0]  dout_q,
  output logic           den_q,
  output logic [DW-1:0]  rdata_q,
  output logic           done_q
);
  logic [NCS-1:0] sel_n;
  logic           cur_rd_q;
  logic           cur_early_q;

  for (genvar g = 0; g < NCS; g++) begin : g_dec
    assign sel_n[g] = (cs != CSW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ncs_q       <= '1;
      addr_q      <= '0;
      rd_q        <= 1'b1;
      oe_q        <= 1'b1;
      we_q        <= 1'b1;
      dout_q      <= '0;
      den_q       <= 1'b0;
      rdata_q     <= '0;
      done_q      <= 1'b0;
      cur_rd_q    <= 1'b0;
      cur_early_q <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin && cur_rd_q) rdata_q <= bus_din;
      if (start) begin
        ncs_q       <= sel_n;
        addr_q      <= addr;
        dout_q      <= wdata;
        den_q       <= wr;
        we_q        <= 1'b1;
        rd_q        <= !(!wr && mode_early);
        oe_q        <= !(!wr && mode_early);
        cur_rd_q    <= !wr;
        cur_early_q <= mode_early;
      end else if (step) begin
        rd_q <= !cur_rd_q;
        oe_q <= !cur_rd_q;
        we_q <= cur_rd_q;
      end else if (fin) begin
        ncs_q <= '1;
        rd_q  <= 1'b1;
        oe_q  <= 1'b1;
        we_q  <= 1'b1;
        den_q <= 1'b0;
      end
    end
  end

  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ncs_q));
  p_strobe_needs_cs_r3: assert property (@(posedge clk) disable iff (rst)
    (!rd_q || !we_q) |-> (ncs_q != '1));
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!rd_q && !we_q));
  p_std_rd_delay_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_q) && !cur_early_q) |-> ($stable(ncs_q) && $stable(addr_q)));
  p_we_delay_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(we_q) |-> ($stable(ncs_q) && $stable(addr_q)));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/ext_strobe_seq.sv
module ext_strobe_seq #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int NCS = 4,
  parameter int WSW = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic           cfg_early,
  input  logic           req,
  input  logic           wr,
  input  logic [CSW-1:0] cs,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [WSW-1:0] wait_states,
  output logic           ack,
  output logic           done,
  output logic [DW-1:0]  rdata,
  output logic [NCS-1:0] bus_ncs_n,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_rd_n,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_dout_en,
  input  logic [DW-1:0]  bus_din
);
  logic mode_early;
  logic step;
  logic fin;

  always_ff @(posedge clk) begin
    if (rst)         mode_early <= 1'b0;
    else if (cfg_we) mode_early <= cfg_early;
  end

  esq_timer #(.CSW(CSW), .WSW(WSW)) u_timer (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .cs(cs),
    .wait_states(wait_states), .mode_early(mode_early),
    .ack(ack), .step(step), .fin(fin)
  );

  esq_drive #(.AW(AW), .DW(DW), .NCS(NCS), .CSW(CSW)) u_drive (
    .clk(clk), .rst(rst), .start(ack), .step(step), .fin(fin),
    .wr(wr), .cs(cs), .addr(addr), .wdata(wdata), .mode_early(mode_early),
    .bus_din(bus_din),
    .ncs_q(bus_ncs_n), .addr_q(bus_addr), .rd_q(bus_rd_n), .oe_q(bus_oe_n),
    .we_q(bus_we_n), .dout_q(bus_dout), .den_q(bus_dout_en),
    .rdata_q(rdata), .done_q(done)
  );

  // R7: output enable tracks the read strobe
  p_oe_follows_rd_r7: assert property (@(posedge clk) disable iff (rst)
    bus_oe_n == bus_rd_n);
endmodule

// File: tb/test_ext_strobe_seq.sv
module test_ext_strobe_seq;
  localparam int AW = 16, DW = 16, NCS = 4, WSW = 4, CSW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_early = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [CSW-1:0] cs = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [WSW-1:0] wait_states = '0;
  logic [DW-1:0] bus_din = '0;
  logic ack, done, bus_rd_n, bus_oe_n, bus_we_n, bus_dout_en;
  logic [DW-1:0] rdata, bus_dout;
  logic [NCS-1:0] bus_ncs_n;
  logic [AW-1:0] bus_addr;

  ext_strobe_seq #(.AW(AW), .DW(DW), .NCS(NCS), .WSW(WSW)) i_ext_strobe_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_early(cfg_early), .req(req),
    .wr(wr), .cs(cs), .addr(addr), .wdata(wdata), .wait_states(wait_states),
    .ack(ack), .done(done), .rdata(rdata), .bus_ncs_n(bus_ncs_n),
    .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0, cmp_on = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // behavioural reference: state 0 idle, 1 access, 2 quiet
  int m_st = 0, m_cnt = 0, m_cs = 0, m_gap = 0;
  bit m_rd = 0, m_early = 0, m_mode = 0, m_took = 0;
  logic [NCS-1:0] e_ncs = '1;
  logic [AW-1:0] e_addr = '0;
  logic e_rd_n = 1, e_we_n = 1, e_den = 0, e_done = 0;
  logic [DW-1:0] e_dout = '0, e_rdata = '0;

  function automatic bit m_ack_f();
    return req && (m_st == 0 ||
      (m_st == 1 && m_cnt == 0 && m_early && m_rd && !wr && int'(cs) == m_cs));
  endfunction

  always @(posedge clk) begin
    bit a, f;
    m_took = 0;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_cs = 0; m_gap = 0; m_rd = 0; m_early = 0; m_mode = 0;
      e_ncs = '1; e_addr = '0; e_rd_n = 1; e_we_n = 1; e_den = 0; e_done = 0;
      e_dout = '0; e_rdata = '0;
    end else begin
      a = m_ack_f();
      f = (m_st == 1 && m_cnt == 0);
      e_done = f;
      if (f && m_rd) e_rdata = bus_din;
      if (a) begin
        m_took = 1; m_st = 1; m_cnt = 2 * (int'(wait_states) + 1) - 1;
        m_rd = !wr; m_early = m_mode; m_cs = int'(cs);
        e_ncs = '1; e_ncs[cs] = 1'b0; e_addr = addr; e_dout = wdata; e_den = wr;
        e_we_n = 1; e_rd_n = !(!wr && m_mode);
      end else if (m_st == 1 && m_cnt != 0) begin
        m_cnt--; e_rd_n = !m_rd; e_we_n = m_rd;
      end else if (f) begin
        e_ncs = '1; e_rd_n = 1; e_we_n = 1; e_den = 0;
        if (m_early && m_rd) begin m_st = 2; m_gap = 1; end
        else m_st = 0;
      end else if (m_st == 2) begin
        if (m_gap == 0) m_st = 0; else m_gap = 0;
      end
      if (cfg_we) m_mode = cfg_early;
    end
  end

  // read data source changes every clock so the capture edge is visible
  always @(negedge clk) bus_din <= bus_din * 16'd5 + 16'd7;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 ncs", bus_ncs_n, e_ncs);
      chk("R3 addr", bus_addr, e_addr);
      chk("R1 R4 R5 R9 rd_n", bus_rd_n, e_rd_n);
      chk("R7 oe_n", bus_oe_n, e_rd_n);
      chk("R6 we_n", bus_we_n, e_we_n);
      chk("R6 dout_en", bus_dout_en, e_den);
      if (e_den) chk("R6 dout", bus_dout, e_dout);
      chk("R8 done", done, e_done);
      chk("R8 rdata", rdata, e_rdata);
      #2;
      chk("R9 R10 ack", ack, m_ack_f());
    end
  end

  // request list
  bit q_wr[16]; int q_cs[16], q_ws[16], q_dly[16];
  logic [AW-1:0] q_addr[16]; logic [DW-1:0] q_wd[16];
  int nq = 0;
  localparam int SW = 6;

  task automatic add(input bit w, input int c, input int a, input int d, input int ws, input int dl);
    q_wr[nq] = w; q_cs[nq] = c; q_addr[nq] = AW'(a); q_wd[nq] = DW'(d);
    q_ws[nq] = ws; q_dly[nq] = dl; nq++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired at %0t", $time);
    wrap_up();
  end

  initial begin
    // delayed timing (reset default, R1)
    add(0, 0, 'h0100, 0, 0, 2);
    add(1, 1, 'h0204, 'hA5A5, 0, 0);
    add(0, 1, 'h0208, 0, 2, 0);
    add(0, 1, 'h020C, 0, 0, 0);
    add(1, 3, 'h0300, 'h1234, 3, 1);
    add(0, 2, 'h0404, 0, 15, 0);
    // early timing
    add(0, 0, 'h0010, 0, 0, 0);
    add(0, 0, 'h0012, 0, 1, 0);
    add(0, 0, 'h0014, 0, 0, 0);
    add(1, 0, 'h0016, 'h5A5A, 0, 0);
    add(0, 2, 'h0020, 0, 1, 0);
    add(0, 3, 'h0030, 0, 0, 0);
    add(1, 1, 'h0040, 'hBEEF, 2, 3);
    add(0, 1, 'h0044, 0, 0, 0);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    chk("R2 ncs", bus_ncs_n, {NCS{1'b1}});
    chk("R2 rd_n", bus_rd_n, 1);
    chk("R2 oe_n", bus_oe_n, 1);
    chk("R2 we_n", bus_we_n, 1);
    chk("R2 done", done, 0);
    chk("R2 dout_en", bus_dout_en, 0);
    cmp_on = 1;

    for (int i = 0; i < nq; i++) begin
      if (i == SW) begin
        repeat (6) @(negedge clk);
        cfg_we = 1'b1; cfg_early = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
      end
      repeat (q_dly[i]) @(negedge clk);
      wr = q_wr[i]; cs = CSW'(q_cs[i]); addr = q_addr[i]; wdata = q_wd[i];
      wait_states = WSW'(q_ws[i]); req = 1'b1;
      forever begin
        @(posedge clk); #1;
        if (m_took) break;
      end
      @(negedge clk);
      req = 1'b0;
    end
    repeat (40) @(negedge clk);
    wrap_up();
  end
endmodule